// File: doc/BRIEF.md
# Streaming 3x3 Binary Morphology Filter

This block applies a 3x3 erosion or dilation to a binary video stream carried on AXI4-Stream. Pixels arrive in raster order, one per beat. The first pixel of a frame is flagged on TUSER, and the last pixel of each row is flagged on TLAST. Each incoming byte is reduced to one bit, where any nonzero value counts as white and zero counts as black. Black is the foreground, and the structuring element is a 3x3 mask of zeros. In erosion mode a pixel turns black only when its whole neighbourhood is black. In dilation mode a pixel turns black when any pixel in its neighbourhood is black. Filtered pixels are driven as all zeros or all ones.

The window is anchored at its bottom-right corner on the pixel being received. The result for the window's centre therefore leaves the block in the slot of the current input pixel, which shifts the filtered image by one row and one column. Some positions get no filtering: rows 0 and 1 of a frame, columns 0 and 1, and the last column (IMG_W-1). For those positions the input byte is forwarded untouched. Two one-bit line stores and three two-bit column shifters hold the neighbourhood. Every beat passes through exactly one output register stage, and that stage follows standard valid/ready flow control.

Top module: `morph3_stream`

## Requirements
- R1: An accepted input beat appears at the output on the clock edge after acceptance, and beats leave in input order, one output beat per input beat.
- R2: Pixels in frame rows 0 and 1 are output with their input byte unchanged.
- R3: Pixels in columns 0, 1 and IMG_W-1 are output with their input byte unchanged.
- R4: With mode_i=0 (erosion), the output for a pixel at row r>=2, column c in 2..IMG_W-2 is 0 when all nine pixels at rows r-2..r and columns c-2..c are black, and all ones otherwise.
- R5: With mode_i=1 (dilation), the output for such a pixel is 0 when at least one of those nine pixels is black, and all ones otherwise.
- R6: An input byte of any nonzero value is treated as white in the window, and a zero byte is treated as black.
- R7: A beat with s_tuser_i=1 is position (row 0, column 0), even in the middle of a row. The beat after a beat with s_tlast_i=1 is column 0 of the next row.
- R8: m_tuser_o and m_tlast_o carry the TUSER and TLAST values of the same beat as m_tdata_o.
- R9: While m_tvalid_o=1 and m_tready_i=0, the output beat is held unchanged and s_tready_o is 0.
- R10: During and right after reset, m_tvalid_o is 0 and s_tready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 selects erosion, 1 selects dilation |
| s_tvalid_i | input | 1 | Input beat valid |
| s_tready_o | output | 1 | Input beat accepted when high with valid |
| s_tdata_i | input | PIX_W | Input pixel |
| s_tuser_i | input | 1 | First pixel of frame |
| s_tlast_i | input | 1 | Last pixel of row |
| m_tvalid_o | output | 1 | Output beat valid |
| m_tready_i | input | 1 | Downstream ready |
| m_tdata_o | output | PIX_W | Output pixel |
| m_tuser_o | output | 1 | First pixel of frame, aligned with m_tdata_o |
| m_tlast_o | output | 1 | Last pixel of row, aligned with m_tdata_o |

## Verification
Corrupted line-store or column-shifter contents do not show in rows 0 and 1. They first appear in a filtered pixel of row 2 or later, one cycle after the affected column is received. To expose them, frames mix sparse and dense black patterns in both modes and use white values other than all ones. A position counter that slips shows up as a border byte that comes out filtered, or as a filtered pixel that comes out raw, at the first misplaced beat. A frame restarted mid-row and a pass with random downstream stalls check that position tracking and the output register do not depend on timing.

// File: rtl/morph3_pkg.sv
package morph3_pkg;
  typedef enum logic {
    MORPH_ERODE  = 1'b0,
    MORPH_DILATE = 1'b1
  } morph_mode_e;

  localparam int unsigned WIN_TAPS = 9;
  localparam logic [1:0]  ROW_SAT  = 2'd2;  // rows >= 2 are filterable
endpackage

// File: rtl/morph3_pos_track.sv
module morph3_pos_track
  import morph3_pkg::*;
#(
  parameter int unsigned IMG_W = 640
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       adv_i,
  input  logic                       user_i,
  input  logic                       last_i,
  output logic [$clog2(IMG_W)-1:0]   col_o,
  output logic [1:0]                 row_o
);
  localparam int unsigned CW = $clog2(IMG_W);
  localparam logic [CW-1:0] COL_MAX = CW'(IMG_W - 1);

  logic [CW-1:0] col_q;
  logic [1:0]    row_q;

  // TUSER overrides stored position for the current beat
  always_comb begin
    col_o = user_i ? '0 : col_q;
    row_o = user_i ? '0 : row_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
    end else if (adv_i) begin
      if (last_i) begin
        col_q <= '0;
        row_q <= (row_o == ROW_SAT) ? ROW_SAT : row_o + 2'd1;
      end else begin
        col_q <= (col_o == COL_MAX) ? COL_MAX : col_o + 1'b1;
        row_q <= row_o;
      end
    end
  end

  assert_eol_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && last_i |=> col_q == '0);

  assert_sof_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && user_i && !last_i |=> col_q == CW'(1) && row_q == 2'd0);
endmodule

// File: rtl/morph3_line_win.sv
module morph3_line_win
  import morph3_pkg::*;
#(
  parameter int unsigned IMG_W = 640
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       adv_i,
  input  logic [$clog2(IMG_W)-1:0]   col_i,
  input  logic                       pix_i,
  output logic [WIN_TAPS-1:0]        win_o
);
  localparam int unsigned CW     = $clog2(IMG_W);
  localparam int unsigned STORE_N = IMG_W - 1;  // last column never enters a window

  logic [STORE_N-1:0] top_q, mid_q;
  logic               top_rd, mid_rd;
  logic [1:0]         top_sh_q, mid_sh_q, bot_sh_q;

  always_comb begin
    top_rd = 1'b0;
    mid_rd = 1'b0;
    for (int i = 0; i < STORE_N; i++) begin
      if (col_i == CW'(i)) begin
        top_rd = top_q[i];
        mid_rd = mid_q[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q <= '0;
      mid_q <= '0;
    end else if (adv_i) begin
      for (int i = 0; i < STORE_N; i++) begin
        if (col_i == CW'(i)) begin
          top_q[i] <= mid_q[i];
          mid_q[i] <= pix_i;
        end
      end
    end
  end

  // sh[0] = column c-1, sh[1] = column c-2
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_sh_q <= '0;
      mid_sh_q <= '0;
      bot_sh_q <= '0;
    end else if (adv_i) begin
      top_sh_q <= {top_sh_q[0], top_rd};
      mid_sh_q <= {mid_sh_q[0], mid_rd};
      bot_sh_q <= {bot_sh_q[0], pix_i};
    end
  end

  assign win_o = {top_sh_q[1], top_sh_q[0], top_rd,
                  mid_sh_q[1], mid_sh_q[0], mid_rd,
                  bot_sh_q[1], bot_sh_q[0], pix_i};

  assert_shift_bottom_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> bot_sh_q[0] == $past(pix_i));
endmodule

// File: rtl/morph3_kernel.sv
module morph3_kernel
  import morph3_pkg::*;
#(
  parameter int unsigned PIX_W = 8
) (
  input  logic                 mode_i,
  input  logic [WIN_TAPS-1:0]  win_i,
  output logic [PIX_W-1:0]     pix_o
);
  logic all_black, any_black, black;

  always_comb begin
    all_black = ~|win_i;
    any_black = ~&win_i;
    black     = (morph_mode_e'(mode_i) == MORPH_ERODE) ? all_black : any_black;
    pix_o     = black ? '0 : '1;
  end
endmodule

// File: rtl/morph3_out_stage.sv
module morph3_out_stage #(
  parameter int unsigned PIX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             s_valid_i,
  output logic             s_ready_o,
  input  logic [PIX_W-1:0] data_i,
  input  logic             user_i,
  input  logic             last_i,
  output logic             m_valid_o,
  input  logic             m_ready_i,
  output logic [PIX_W-1:0] m_data_o,
  output logic             m_user_o,
  output logic             m_last_o
);
  logic             vld_q;
  logic [PIX_W-1:0] data_q;
  logic             user_q, last_q;

  assign s_ready_o = !vld_q || m_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      user_q <= 1'b0;
      last_q <= 1'b0;
    end else if (s_ready_o) begin
      vld_q <= s_valid_i;
      if (s_valid_i) begin
        data_q <= data_i;
        user_q <= user_i;
        last_q <= last_i;
      end
    end
  end

  assign m_valid_o = vld_q;
  assign m_data_o  = data_q;
  assign m_user_o  = user_q;
  assign m_last_o  = last_q;

  assert_one_cycle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_valid_i && s_ready_o |=> m_valid_o && m_data_o == $past(data_i));

  assert_sideband_align_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_valid_i && s_ready_o |=> m_user_o == $past(user_i) && m_last_o == $past(last_i));

  assert_hold_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_data_o) && $stable(m_user_o)
                               && $stable(m_last_o));
endmodule

// File: rtl/morph3_stream.sv
module morph3_stream
  import morph3_pkg::*;
#(
  parameter int unsigned IMG_W = 640,
  parameter int unsigned PIX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             s_tvalid_i,
  output logic             s_tready_o,
  input  logic [PIX_W-1:0] s_tdata_i,
  input  logic             s_tuser_i,
  input  logic             s_tlast_i,
  output logic             m_tvalid_o,
  input  logic             m_tready_i,
  output logic [PIX_W-1:0] m_tdata_o,
  output logic             m_tuser_o,
  output logic             m_tlast_o
);
  localparam int unsigned CW = $clog2(IMG_W);
  localparam logic [CW-1:0] COL_FIRST = CW'(2);
  localparam logic [CW-1:0] COL_LAST  = CW'(IMG_W - 2);

  logic                accept;
  logic [CW-1:0]       col;
  logic [1:0]          row;
  logic                in_region;
  logic [WIN_TAPS-1:0] win;
  logic [PIX_W-1:0]    filt_pix, sel_pix;

  assign accept = s_tvalid_i && s_tready_o;

  morph3_pos_track #(.IMG_W(IMG_W)) u_pos (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (accept),
    .user_i(s_tuser_i),
    .last_i(s_tlast_i),
    .col_o (col),
    .row_o (row)
  );

  morph3_line_win #(.IMG_W(IMG_W)) u_win (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (accept),
    .col_i (col),
    .pix_i (|s_tdata_i),
    .win_o (win)
  );

  morph3_kernel #(.PIX_W(PIX_W)) u_kernel (
    .mode_i(mode_i),
    .win_i (win),
    .pix_o (filt_pix)
  );

  assign in_region = (row == ROW_SAT) && (col >= COL_FIRST) && (col <= COL_LAST);
  assign sel_pix   = in_region ? filt_pix : s_tdata_i;

  morph3_out_stage #(.PIX_W(PIX_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .s_valid_i(s_tvalid_i),
    .s_ready_o(s_tready_o),
    .data_i   (sel_pix),
    .user_i   (s_tuser_i),
    .last_i   (s_tlast_i),
    .m_valid_o(m_tvalid_o),
    .m_ready_i(m_tready_i),
    .m_data_o (m_tdata_o),
    .m_user_o (m_tuser_o),
    .m_last_o (m_tlast_o)
  );

  assert_top_rows_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && row != ROW_SAT |=> m_tdata_o == $past(s_tdata_i));

  assert_edge_cols_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && row == ROW_SAT && !in_region |=> m_tdata_o == $past(s_tdata_i));

  assert_erode_white_in_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && in_region && !mode_i && (|s_tdata_i) |=> m_tdata_o == '1);

  assert_dilate_black_in_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && in_region && mode_i && !(|s_tdata_i) |=> m_tdata_o == '0);
endmodule

// File: tb/morph3_stream_bench.sv
`timescale 1ns/1ps
module morph3_stream_bench;
  localparam int W  = 6;
  localparam int H  = 5;
  localparam int NB = W * H;
  localparam int NCASE = 10;
  // {mode[24], white[23:16], seed[15:8], dens[7:0]}; pixel is black when hash < dens
  localparam logic [24:0] CASES [NCASE] = '{
    {1'b0, 8'hFF, 8'd1, 8'd4},
    {1'b1, 8'hFF, 8'd2, 8'd4},
    {1'b0, 8'hFF, 8'd3, 8'd1},
    {1'b1, 8'hFF, 8'd4, 8'd1},
    {1'b0, 8'hFF, 8'd5, 8'd7},
    {1'b1, 8'hFF, 8'd6, 8'd8},
    {1'b0, 8'hFF, 8'd0, 8'd8},
    {1'b1, 8'hFF, 8'd0, 8'd0},
    {1'b0, 8'h33, 8'd7, 8'd3},
    {1'b1, 8'h80, 8'd9, 8'd2}
  };

  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic       rst_ni = 1'b0;
  logic       mode = 1'b0;
  logic       s_tvalid = 1'b0, s_tuser = 1'b0, s_tlast = 1'b0;
  logic [7:0] s_tdata = 8'h00;
  logic       s_tready;
  logic       m_tvalid, m_tuser, m_tlast;
  logic       m_tready = 1'b1;
  logic [7:0] m_tdata;

  morph3_stream #(.IMG_W(W), .PIX_W(8)) u_morph3_stream (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .s_tvalid_i(s_tvalid),
    .s_tready_o(s_tready),
    .s_tdata_i (s_tdata),
    .s_tuser_i (s_tuser),
    .s_tlast_i (s_tlast),
    .m_tvalid_o(m_tvalid),
    .m_tready_i(m_tready),
    .m_tdata_o (m_tdata),
    .m_tuser_o (m_tuser),
    .m_tlast_o (m_tlast)
  );

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;
  bit  stall_en = 0, tready_hold = 1;
  logic [7:0] lfsr = 8'h5B;

  logic [7:0] cap_d [64];
  bit         cap_u [64];
  bit         cap_l [64];
  int         cap_n = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // downstream ready, changed at negedge+1
  initial forever begin
    @(negedge clk_i); #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    m_tready = stall_en ? (lfsr[0] | lfsr[2]) : tready_hold;
  end

  // monitor: values at negedge+2 equal those at the next posedge
  initial forever begin
    @(negedge clk_i); #2;
    if (m_tvalid && m_tready && cap_n < 64) begin
      cap_d[cap_n] = m_tdata;
      cap_u[cap_n] = m_tuser;
      cap_l[cap_n] = m_tlast;
      cap_n++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic send_beat(input logic [7:0] d, input logic u, input logic l);
    @(negedge clk_i); #1;
    s_tvalid = 1'b1; s_tdata = d; s_tuser = u; s_tlast = l;
    #1;
    while (!s_tready) begin @(negedge clk_i); #2; end
    @(posedge clk_i);
  endtask

  task automatic go_idle();
    @(negedge clk_i); #1;
    s_tvalid = 1'b0; s_tuser = 1'b0; s_tlast = 1'b0;
  endtask

  task automatic drain(input int want);
    int t = 0;
    while (cap_n < want && t < 400) begin @(negedge clk_i); #3; t++; end
    repeat (2) @(negedge clk_i);
  endtask

  function automatic bit pbit(int r, int c, logic [7:0] seed, logic [7:0] dens);
    int h = (r * 5 + c * 3 + int'(seed) * 11 + r * c * 7) % 8;
    return h >= int'(dens);
  endfunction

  function automatic logic [7:0] exp_pix(int r, int c, logic m, logic [7:0] w,
                                         logic [7:0] seed, logic [7:0] dens);
    bit all0 = 1, any0 = 0, blk;
    if (r < 2 || c < 2 || c == W - 1) return pbit(r, c, seed, dens) ? w : 8'h00;
    for (int dr = 0; dr < 3; dr++)
      for (int dc = 0; dc < 3; dc++)
        if (pbit(r - 2 + dr, c - 2 + dc, seed, dens)) all0 = 0; else any0 = 1;
    blk = m ? any0 : all0;
    return blk ? 8'h00 : 8'hFF;
  endfunction

  task automatic send_frame(input logic [7:0] w, input logic [7:0] seed, input logic [7:0] dens);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++)
        send_beat(pbit(r, c, seed, dens) ? w : 8'h00, (r == 0 && c == 0), (c == W - 1));
    go_idle();
  endtask

  task automatic check_frame(input logic m, input logic [7:0] w, input logic [7:0] seed,
                             input logic [7:0] dens, input string pre);
    chk(cap_n == NB, {pre, "R1 beat count"}, cap_n, NB);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        int idx = r * W + c;
        logic [7:0] e = exp_pix(r, c, m, w, seed, dens);
        string tg;
        if (r < 2) tg = "R2";
        else if (c < 2 || c == W - 1) tg = "R3";
        else if (w != 8'hFF) tg = "R6";
        else tg = m ? "R5" : "R4";
        chk(cap_d[idx] == e, {pre, tg}, cap_d[idx], e);
        chk(cap_u[idx] == (idx == 0) && cap_l[idx] == (c == W - 1), {pre, "R8"},
            {cap_u[idx], cap_l[idx]}, {(idx == 0), (c == W - 1)});
      end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #3;
    chk(m_tvalid == 1'b0, "R10 valid in reset", m_tvalid, 0);
    chk(s_tready == 1'b1, "R10 ready in reset", s_tready, 1);
    @(negedge clk_i); rst_ni = 1'b1;
    #3;
    chk(m_tvalid == 1'b0, "R10 valid after reset", m_tvalid, 0);

    // R1: single beat, one cycle through
    send_beat(8'h5A, 1'b1, 1'b0);
    @(negedge clk_i); #1;
    s_tvalid = 1'b0; s_tuser = 1'b0;
    #1;
    chk(m_tvalid == 1'b1, "R1 valid", m_tvalid, 1);
    chk(m_tdata == 8'h5A, "R1 data", m_tdata, 8'h5A);
    chk(m_tuser == 1'b1, "R8 user", m_tuser, 1);

    // R9: stall holds output and blocks input
    tready_hold = 0;
    send_beat(8'h11, 1'b0, 1'b0);
    @(negedge clk_i); #1;
    s_tvalid = 1'b1; s_tdata = 8'h22; s_tuser = 1'b0; s_tlast = 1'b0;
    #1;
    chk(s_tready == 1'b0, "R9 ready low", s_tready, 0);
    chk(m_tdata == 8'h11, "R9 data held", m_tdata, 8'h11);
    repeat (3) begin
      @(negedge clk_i); #2;
      chk(m_tvalid && m_tdata == 8'h11, "R9 hold", m_tdata, 8'h11);
      chk(!s_tready, "R9 blocked", s_tready, 0);
    end
    tready_hold = 1;
    while (!s_tready) begin @(negedge clk_i); #2; end
    @(posedge clk_i);
    @(negedge clk_i); #1;
    s_tvalid = 1'b0;
    #1;
    chk(m_tvalid && m_tdata == 8'h22, "R9 release", m_tdata, 8'h22);
    repeat (3) @(negedge clk_i);

    // R7: abandoned partial frame, next frame restarts on TUSER mid-row
    for (int k = 0; k < 9; k++) send_beat(8'h00, (k == 0), ((k % W) == W - 1));
    go_idle();
    drain(9);

    for (int pass = 0; pass < 2; pass++) begin
      stall_en = (pass == 1);
      for (int i = 0; i < NCASE; i++) begin
        logic [24:0] cs = CASES[i];
        mode  = cs[24];
        cap_n = 0;
        send_frame(cs[23:16], cs[15:8], cs[7:0]);
        drain(NB);
        check_frame(cs[24], cs[23:16], cs[15:8], cs[7:0],
                    (pass == 0 && i == 0) ? "R7/" : (pass == 1 ? "R9/" : ""));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule